// File: doc/BRIEF.md
# Oversampled Serial Receiver with Holding Register and Error Flags

This block is the receive half of an asynchronous serial port. The incoming line is synchronised to the system clock. It is then examined on a sample tick that runs at sixteen times the bit rate. Each bit is decided by a majority vote of three samples taken around its centre. A start bit that does not survive to mid-bit is discarded as a glitch.

Four frame layouts are supported, selected by a two-bit mode input. Each completed word passes to a holding register, which raises a full flag until a read strobe empties it. Along with the word, the register latches the framing and noise conditions seen in that frame. It also records an overrun when a further frame finishes before the held word is read, and a break when ten bit periods in a row are sampled low.

One interrupt request line combines the full, overrun and break conditions, each gated by its own enable input. The baud tick is generated outside the block. The logic that moves the word into processor storage is also outside the block.

Top module: `srx_receiver`

## Requirements
- R1: After reset, rx_full, frame_err, noise_err, overrun_err, break_err and irq are 0, and rx_data is 0.
- R2: frame_mode 2'b00 receives a start bit, 8 data bits sent least significant bit first, and 1 stop bit. The word appears on rx_data[7:0] with rx_data[8]=0, and rx_full becomes 1.
- R3: frame_mode 2'b11 receives 9 data bits, least significant bit first, followed by 1 stop bit. The ninth bit received appears on rx_data[8].
- R4: frame_mode 2'b01 receives 8 data bits, a parity bit and 1 stop bit. With parity_odd=0 the data bits plus the parity bit must hold an even number of ones; with parity_odd=1, an odd number. A mismatch sets frame_err, and the word is still loaded.
- R5: A stop-bit slot sampled low sets frame_err. frame_mode 2'b10 has two stop slots, and either one being low counts.
- R6: Each bit is sampled on the 8th, 9th and 10th sample ticks of its 16-tick period, and the majority value is taken. If the three samples of any bit in the frame disagree, noise_err is set when the word is loaded.
- R7: A falling edge on the line whose start-bit majority is high is ignored. No word is loaded, and no flag changes.
- R8: Ten consecutive bit periods sampled low set break_err. After a frame whose final stop slot was low, the receiver waits for the line to return high before it accepts a new start bit.
- R9: If a frame completes while rx_full is 1 and no read strobe is present, overrun_err is set. rx_data, frame_err and noise_err keep their held values.
- R10: A one-cycle rd_strobe clears rx_full, frame_err, noise_err, overrun_err and break_err.
- R11: irq is 1 exactly when at least one of these holds: (ie_full and rx_full), (ie_overrun and overrun_err), or (ie_break and break_err).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input line, idle high |
| frame_mode | input | 2 | Frame layout select (see R2 to R5) |
| parity_odd | input | 1 | 0 selects even parity, 1 selects odd |
| rd_strobe | input | 1 | Empties the holding register and clears its flags |
| ie_full | input | 1 | Interrupt enable for received-word-full |
| ie_overrun | input | 1 | Interrupt enable for overrun |
| ie_break | input | 1 | Interrupt enable for break |
| rx_data | output | 9 | Held received word |
| rx_full | output | 1 | Holding register contains an unread word |
| frame_err | output | 1 | Parity or stop-bit failure in the held word |
| noise_err | output | 1 | Sample disagreement in the held word |
| overrun_err | output | 1 | A frame was lost because the register was full |
| break_err | output | 1 | Ten consecutive low bit periods were seen |
| irq | output | 1 | Combined enabled interrupt request |

## Verification
The noise condition is the hardest case to reach from the ports, because it depends on where the three centre samples fall within a bit. The bench drives the line in whole sample ticks, each line change made just after a tick is consumed, so that every bit spans exactly sixteen ticks from the detected start. A noisy bit then holds its value for nine ticks and the inverse for seven, so that only the third sample disagrees. The break case holds the line low past the end of the frame and issues a read strobe part way through, to show that no phantom frame follows.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_BITS,
    FS_WAIT_HIGH
  } frm_state_t;

  localparam logic [1:0] MODE_8N1 = 2'b00;
  localparam logic [1:0] MODE_8P1 = 2'b01;
  localparam logic [1:0] MODE_8N2 = 2'b10;
  localparam logic [1:0] MODE_9N1 = 2'b11;

  // Index of the final bit slot (start bit is slot 0).
  function automatic logic [3:0] last_slot(input logic [1:0] mode);
    return (mode == MODE_8N1) ? 4'd9 : 4'd10;
  endfunction

  function automatic logic is_stop_slot(input logic [1:0] mode, input logic [3:0] slot);
    case (mode)
      MODE_8N1: return slot == 4'd9;
      MODE_8N2: return (slot == 4'd9) || (slot == 4'd10);
      default:  return slot == 4'd10;
    endcase
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic disagree3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction

  // True when data plus parity bit meet the selected polarity.
  function automatic logic parity_ok(input logic [7:0] d, input logic p, input logic odd);
    return (^{d, p}) == odd;
  endfunction

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_bit_sampler.sv
module srx_bit_sampler #(
  parameter int OVS        = 16,
  parameter int SAMPLE_MID = 8,
  localparam int PH_W      = $clog2(OVS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            en,
  input  logic            line,
  input  logic [PH_W-1:0] phase,
  output logic            bit_strobe,
  output logic            bit_val,
  output logic            bit_noisy
);
  import srx_pkg::*;

  logic samp_a, samp_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (tick && en) begin
      if (phase == PH_W'(SAMPLE_MID - 1)) samp_a <= line;
      if (phase == PH_W'(SAMPLE_MID))     samp_b <= line;
    end
  end

  // Third sample is the live line on the decision tick.
  assign bit_strobe = tick && en && (phase == PH_W'(SAMPLE_MID + 1));
  assign bit_val    = vote3(samp_a, samp_b, line);
  assign bit_noisy  = disagree3(samp_a, samp_b, line);
endmodule

// File: rtl/srx_framer.sv
module srx_framer #(
  parameter int OVS        = 16,
  parameter int BREAK_BITS = 10,
  localparam int PH_W      = $clog2(OVS),
  localparam int RUN_W     = $clog2(BREAK_BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line,
  input  logic [1:0]      mode,
  input  logic            parity_odd,
  input  logic            bit_strobe,
  input  logic            bit_val,
  input  logic            bit_noisy,
  output logic [PH_W-1:0] phase,
  output logic            sampling,
  output logic            done,
  output logic            brk,
  output logic [8:0]      word_o,
  output logic            ferr_o,
  output logic            nerr_o
);
  import srx_pkg::*;

  frm_state_t       state;
  logic [3:0]       slot;
  logic [8:0]       word, word_nx;
  logic             ferr, ferr_nx;
  logic             nerr, nerr_nx;
  logic [RUN_W-1:0] run;

  assign sampling = (state == FS_BITS);

  always_comb begin
    word_nx = word;
    for (int k = 0; k < 8; k++) begin
      if (slot == 4'(k + 1)) word_nx[k] = bit_val;
    end
    if (mode == MODE_9N1 && slot == 4'd9) word_nx[8] = bit_val;
    ferr_nx = ferr
            | (is_stop_slot(mode, slot) && !bit_val)
            | (mode == MODE_8P1 && slot == 4'd9 && !parity_ok(word[7:0], bit_val, parity_odd));
    nerr_nx = nerr | bit_noisy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      phase  <= '0;
      slot   <= '0;
      word   <= '0;
      ferr   <= 1'b0;
      nerr   <= 1'b0;
      run    <= '0;
      done   <= 1'b0;
      brk    <= 1'b0;
      word_o <= '0;
      ferr_o <= 1'b0;
      nerr_o <= 1'b0;
    end else begin
      done <= 1'b0;
      brk  <= 1'b0;
      if (tick) begin
        case (state)
          FS_IDLE: begin
            if (!line) begin
              state <= FS_BITS;
              phase <= PH_W'(1);
              slot  <= '0;
              word  <= '0;
              ferr  <= 1'b0;
              nerr  <= 1'b0;
              run   <= '0;
            end
          end
          FS_BITS: begin
            phase <= phase + 1'b1;
            if (phase == PH_W'(OVS - 1)) slot <= slot + 4'd1;
            if (bit_strobe) begin
              if (slot == 4'd0) begin
                if (bit_val) state <= FS_IDLE;      // start glitch
                else begin
                  run  <= RUN_W'(1);
                  nerr <= bit_noisy;
                end
              end else begin
                word <= word_nx;
                ferr <= ferr_nx;
                nerr <= nerr_nx;
                if (bit_val) run <= '0;
                else if (run < RUN_W'(BREAK_BITS)) begin
                  run <= run + 1'b1;
                  if (run == RUN_W'(BREAK_BITS - 1)) brk <= 1'b1;
                end
                if (slot == last_slot(mode)) begin
                  done   <= 1'b1;
                  word_o <= word_nx;
                  ferr_o <= ferr_nx;
                  nerr_o <= nerr_nx;
                  state  <= bit_val ? FS_IDLE : FS_WAIT_HIGH;
                end
              end
            end
          end
          FS_WAIT_HIGH: begin
            if (line) state <= FS_IDLE;
          end
          default: state <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_hold_reg.sv
module srx_hold_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       brk,
  input  logic [8:0] word,
  input  logic       ferr,
  input  logic       nerr,
  input  logic       rd,
  output logic [8:0] data,
  output logic       full,
  output logic       frame_err,
  output logic       noise_err,
  output logic       overrun_err,
  output logic       break_err
);
  logic lost;
  assign lost = load && full && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data        <= '0;
      full        <= 1'b0;
      frame_err   <= 1'b0;
      noise_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else if (lost) begin
      overrun_err <= 1'b1;
    end else if (load) begin
      data        <= word;
      full        <= 1'b1;
      frame_err   <= ferr;
      noise_err   <= nerr;
      overrun_err <= 1'b0;
    end else if (rd) begin
      full        <= 1'b0;
      frame_err   <= 1'b0;
      noise_err   <= 1'b0;
      overrun_err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   break_err <= 1'b0;
    else if (brk) break_err <= 1'b1;
    else if (rd)  break_err <= 1'b0;
  end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
  parameter int OVS         = 16,
  parameter int SAMPLE_MID  = 8,
  parameter int BREAK_BITS  = 10,
  parameter int SYNC_STAGES = 2,
  localparam int PH_W       = $clog2(OVS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rx_line,
  input  logic [1:0] frame_mode,
  input  logic       parity_odd,
  input  logic       rd_strobe,
  input  logic       ie_full,
  input  logic       ie_overrun,
  input  logic       ie_break,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic       frame_err,
  output logic       noise_err,
  output logic       overrun_err,
  output logic       break_err,
  output logic       irq
);
  logic            line_s;
  logic [PH_W-1:0] phase;
  logic            sampling;
  logic            bit_strobe, bit_val, bit_noisy;
  logic            frm_done, frm_brk;
  logic [8:0]      frm_word;
  logic            frm_ferr, frm_nerr;

  srx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  srx_bit_sampler #(.OVS(OVS), .SAMPLE_MID(SAMPLE_MID)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .en(sampling), .line(line_s),
    .phase(phase), .bit_strobe(bit_strobe), .bit_val(bit_val), .bit_noisy(bit_noisy)
  );

  srx_framer #(.OVS(OVS), .BREAK_BITS(BREAK_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(line_s),
    .mode(frame_mode), .parity_odd(parity_odd),
    .bit_strobe(bit_strobe), .bit_val(bit_val), .bit_noisy(bit_noisy),
    .phase(phase), .sampling(sampling), .done(frm_done), .brk(frm_brk),
    .word_o(frm_word), .ferr_o(frm_ferr), .nerr_o(frm_nerr)
  );

  srx_hold_reg u_hold (
    .clk(clk), .rst_n(rst_n), .load(frm_done), .brk(frm_brk), .word(frm_word),
    .ferr(frm_ferr), .nerr(frm_nerr), .rd(rd_strobe),
    .data(rx_data), .full(rx_full), .frame_err(frame_err), .noise_err(noise_err),
    .overrun_err(overrun_err), .break_err(break_err)
  );

  assign irq = (ie_full & rx_full) | (ie_overrun & overrun_err) | (ie_break & break_err);
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       ie_full,
  input logic       ie_break,
  input logic       frm_done,
  input logic       frm_brk,
  input logic [8:0] rx_data,
  input logic       rx_full,
  input logic       frame_err,
  input logic       noise_err,
  input logic       overrun_err,
  input logic       break_err,
  input logic       irq
);
  assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !rx_full) |=> rx_full);

  assert_flags_need_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err || noise_err || overrun_err) |-> rx_full);

  assert_break_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_brk |=> break_err);

  assert_overrun_keeps_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && rx_full && !rd_strobe) |=> (overrun_err && $stable(rx_data)));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frm_done && !frm_brk) |=>
      (!rx_full && !overrun_err && !frame_err && !noise_err && !break_err));

  assert_full_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && ie_full) |-> irq);

  assert_break_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (break_err && ie_break) |-> irq);
endmodule

bind srx_receiver srx_checker u_chk (.*);

// File: tb/sim_srx_receiver.sv
module sim_srx_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] frame_mode = 2'b00;
  logic       parity_odd = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       ie_full = 1'b0;
  logic       ie_overrun = 1'b0;
  logic       ie_break = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, frame_err, noise_err, overrun_err, break_err, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  srx_receiver u0 (.*);

  always #4 clk = ~clk;   // 125 MHz

  always @(negedge clk) sample_tick <= ~sample_tick;

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic align();
    @(posedge clk iff sample_tick);
    #1;
  endtask

  // Hold the line for n consumed sample ticks.
  task automatic drive(input logic v, input int n);
    rx_line = v;
    repeat (n) @(posedge clk iff sample_tick);
    #1;
  endtask

  task automatic pulse_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  // noisy_slot: bit slot whose third sample is inverted (-1 for none)
  task automatic send_frame(input logic [1:0] mode, input logic [8:0] d, input logic podd,
                            input logic bad_par, input logic bad_stop, input int noisy_slot);
    logic b [0:10];
    int   n;
    b[0] = 1'b0;
    for (int k = 0; k < 8; k++) b[k+1] = d[k];
    b[9] = 1'b1; b[10] = 1'b1;
    n = (mode == 2'b00) ? 10 : 11;
    if (mode == 2'b01) b[9] = (^d[7:0]) ^ podd ^ bad_par;
    if (mode == 2'b11) b[9] = d[8];
    if (bad_stop) b[n-1] = 1'b0;
    frame_mode = mode;
    parity_odd = podd;
    align();
    for (int k = 0; k < n; k++) begin
      if (k == noisy_slot) begin
        drive(b[k], 9);
        drive(~b[k], 7);
      end else begin
        drive(b[k], 16);
      end
    end
    drive(1'b1, 8);
  endtask

  task automatic check_state(input string tag, input logic full, input logic [8:0] data,
                             input logic fe, input logic ne, input logic ov, input logic br);
    @(negedge clk);
    check({tag, " full"},    rx_full, full);
    check({tag, " data"},    rx_data, data);
    check({tag, " frame"},   frame_err, fe);
    check({tag, " noise"},   noise_err, ne);
    check({tag, " overrun"}, overrun_err, ov);
    check({tag, " break"},   break_err, br);
  endtask

  task automatic t_reset();
    check_state("R1 reset", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic t_basic();
    send_frame(2'b00, 9'h0A5, 1'b0, 1'b0, 1'b0, -1);
    check_state("R2 8N1", 1'b1, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_read();
    check_state("R10 read empties", 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_nine_bit();
    send_frame(2'b11, 9'h1C3, 1'b0, 1'b0, 1'b0, -1);
    check_state("R3 9-bit", 1'b1, 9'h1C3, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_read();
  endtask

  task automatic t_parity();
    send_frame(2'b01, 9'h05A, 1'b0, 1'b0, 1'b0, -1);
    check_state("R4 even parity good", 1'b1, 9'h05A, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_read();
    send_frame(2'b01, 9'h0F1, 1'b1, 1'b0, 1'b0, -1);
    check_state("R4 odd parity good", 1'b1, 9'h0F1, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_read();
    send_frame(2'b01, 9'h05A, 1'b1, 1'b1, 1'b0, -1);
    check_state("R4 odd parity bad", 1'b1, 9'h05A, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse_read();
    check_state("R10 frame flag cleared", 1'b0, 9'h05A, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stop();
    send_frame(2'b10, 9'h033, 1'b0, 1'b0, 1'b1, -1);
    check_state("R5 second stop low", 1'b1, 9'h033, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse_read();
    send_frame(2'b00, 9'h0C4, 1'b0, 1'b0, 1'b1, -1);
    check_state("R5 single stop low", 1'b1, 9'h0C4, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse_read();
  endtask

  task automatic t_noise();
    send_frame(2'b00, 9'h03C, 1'b0, 1'b0, 1'b0, 3);
    check_state("R6 noisy bit", 1'b1, 9'h03C, 1'b0, 1'b1, 1'b0, 1'b0);
    pulse_read();
    check_state("R10 noise cleared", 1'b0, 9'h03C, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_glitch();
    align();
    drive(1'b0, 4);
    drive(1'b1, 40);
    check_state("R7 glitch ignored", 1'b0, 9'h03C, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(2'b00, 9'h081, 1'b0, 1'b0, 1'b0, -1);
    check_state("R7 frame after glitch", 1'b1, 9'h081, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_read();
  endtask

  task automatic t_break();
    ie_break = 1'b1;
    frame_mode = 2'b00;
    align();
    drive(1'b0, 16 * 12);
    check_state("R8 break seen", 1'b1, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R11 break irq", irq, 1'b1);
    pulse_read();
    drive(1'b0, 64);
    check_state("R8 no frame while low", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 48);
    check_state("R8 idle after high", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 irq after read", irq, 1'b0);
    ie_break = 1'b0;
  endtask

  task automatic t_overrun();
    ie_overrun = 1'b1;
    send_frame(2'b00, 9'h011, 1'b0, 1'b0, 1'b0, -1);
    check("R11 irq gated off", irq, 1'b0);
    send_frame(2'b00, 9'h022, 1'b0, 1'b0, 1'b1, -1);
    check_state("R9 overrun keeps word", 1'b1, 9'h011, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 overrun irq", irq, 1'b1);
    pulse_read();
    check_state("R10 overrun cleared", 1'b0, 9'h011, 1'b0, 1'b0, 1'b0, 1'b0);
    ie_overrun = 1'b0;
  endtask

  task automatic t_irq_full();
    send_frame(2'b00, 9'h07E, 1'b0, 1'b0, 1'b0, -1);
    @(negedge clk);
    check("R11 full not enabled", irq, 1'b0);
    ie_full = 1'b1;
    @(negedge clk);
    check("R11 full enabled", irq, 1'b1);
    pulse_read();
    @(negedge clk);
    check("R11 full cleared", irq, 1'b0);
    ie_full = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_basic();
    t_nine_bit();
    t_parity();
    t_stop();
    t_noise();
    t_glitch();
    t_break();
    t_overrun();
    t_irq_full();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule